// File: doc/BRIEF.md
# Write-Back Beat Pacer

This block sets the rhythm in which the beats of a cache-line write-back leave on a system bus that has no data handshake. A single start pulse launches a transfer. It carries a 4-bit rhythm code and a line-length selector. From the next cycle on, the pacer raises a data-valid strobe on "send" cycles and keeps it low on "rest" cycles. The rhythm code selects one of sixteen send/rest shapes. The shape repeats until the programmed number of beats has gone out.

Each shape is one send cycle or two back-to-back send cycles, followed by between zero and nine rest cycles. Alongside each valid beat the block drives a beat index, which the surrounding logic uses to pick the outgoing data word. A one-cycle done flag marks the final beat. No rest cycles are appended after the final beat.

Top module: `wb_pacer`

## Requirements
- R1: While reset (rstN low) is held, and in the cycles after reset until a start is accepted, dataValid and done are 0 and beatIdx is 0.
- R2: A start sampled high at a clock edge while the block is idle makes dataValid high in the very next cycle, with beatIdx 0.
- R3: Rhythm code c selects a shape written as (sends, rests). In code order 0..15 the shapes are: (1,0) (2,1) (2,2) (1,1) (2,3) (2,4) (1,2) (2,5) (1,3) (2,6) (1,4) (2,7) (1,5) (2,8) (1,6) (2,9).
- R4: The shape repeats across the line. Beat b is sent in cycle (b div s)*(s+r) + (b mod s) after the first beat, where s and r are the selected send and rest counts. For example, code 5 over 4 beats gives send,send,rest,rest,rest,rest,send,send.
- R5: lineSel picks the beat count: 0 gives 2 beats, 1 gives 4 beats, 2 or 3 gives 8 beats.
- R6: beatIdx counts 0,1,2,... and advances only after a cycle in which dataValid is high. It is back at 0 once the transfer ends.
- R7: done is high for exactly one cycle, together with the final valid beat. In the following cycle dataValid is low and no rest cycles trail the last beat.
- R8: patCode and lineSel are captured when a start is accepted. Changing them during a transfer has no effect on that transfer.
- R9: A start that is high during a transfer, including in the done cycle, is ignored. A start in any later idle cycle is accepted.
- R10: At most one beat is issued per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, honoured only while idle |
| patCode | input | 4 | Rhythm code, captured at launch |
| lineSel | input | 2 | Beat count selector, captured at launch |
| dataValid | output | 1 | High in each cycle that carries a beat |
| beatIdx | output | 3 | Index of the beat being sent |
| done | output | 1 | High together with the final beat |

## Verification
The bench concentrates on the following cases.

- **Wrap-around of short shapes.** Code 0 over eight beats has no rest cycles at all. Code 15 puts the longest rest gap between pairs. A wrong rest counter would stretch, shrink or merge these gaps.
- **Transfer end.** The bench checks that the line stops right after the last send. A design that padded the end with a rest group, or that advanced the index past the line, would show a late or missing done, or a stale beatIdx.
- **Inputs that change during a transfer.** Start is held high and the code and length are scrambled on every cycle of a transfer, through to the done cycle. A pacer that re-sampled these inputs, or restarted on that start, would bend the expected beat timing.

// File: rtl/wb_pacer_pkg.sv
package wb_pacer_pkg;
  localparam int CODE_W  = 4;
  localparam int SEL_W   = 2;
  localparam int MAX_BEATS = 8;
  localparam int IDX_W   = $clog2(MAX_BEATS);
  localparam int MAX_REST = 9;
  localparam int PH_W    = $clog2(MAX_REST + 1);

  typedef struct packed {
    logic [1:0]      sendCnt;
    logic [PH_W-1:0] restCnt;
  } shape_t;

  typedef struct packed {
    logic load;
    logic advBeat;
    logic clrPhase;
    logic incPhase;
  } strobe_t;

  typedef struct packed {
    logic lastBeat;
    logic sendEnd;
    logic restEnd;
    logic noRest;
  } flags_t;

  function automatic shape_t shapeOf(input logic [CODE_W-1:0] code);
    shape_t s;
    case (code)
      4'd0:  s = '{2'd1, PH_W'(0)};
      4'd1:  s = '{2'd2, PH_W'(1)};
      4'd2:  s = '{2'd2, PH_W'(2)};
      4'd3:  s = '{2'd1, PH_W'(1)};
      4'd4:  s = '{2'd2, PH_W'(3)};
      4'd5:  s = '{2'd2, PH_W'(4)};
      4'd6:  s = '{2'd1, PH_W'(2)};
      4'd7:  s = '{2'd2, PH_W'(5)};
      4'd8:  s = '{2'd1, PH_W'(3)};
      4'd9:  s = '{2'd2, PH_W'(6)};
      4'd10: s = '{2'd1, PH_W'(4)};
      4'd11: s = '{2'd2, PH_W'(7)};
      4'd12: s = '{2'd1, PH_W'(5)};
      4'd13: s = '{2'd2, PH_W'(8)};
      4'd14: s = '{2'd1, PH_W'(6)};
      default: s = '{2'd2, PH_W'(9)};
    endcase
    return s;
  endfunction

  function automatic logic [IDX_W-1:0] lastIdxOf(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    return IDX_W'(1);
      2'd1:    return IDX_W'(3);
      default: return IDX_W'(MAX_BEATS - 1);
    endcase
  endfunction
endpackage

// File: rtl/wb_pacer_dp.sv
module wb_pacer_dp
  import wb_pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] patCode,
  input  logic [SEL_W-1:0]  lineSel,
  input  strobe_t           stb,
  output flags_t            flg,
  output logic [IDX_W-1:0]  beatIdx
);
  shape_t           shapeQ;
  logic [IDX_W-1:0] lastIdxQ;
  logic [IDX_W-1:0] beatQ;
  logic [PH_W-1:0]  phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shapeQ   <= '{2'd1, PH_W'(0)};
      lastIdxQ <= '0;
      beatQ    <= '0;
      phaseQ   <= '0;
    end else if (stb.load) begin
      shapeQ   <= shapeOf(patCode);
      lastIdxQ <= lastIdxOf(lineSel);
      beatQ    <= '0;
      phaseQ   <= '0;
    end else begin
      if (stb.advBeat) beatQ <= flg.lastBeat ? '0 : beatQ + 1'b1;
      if (stb.clrPhase)      phaseQ <= '0;
      else if (stb.incPhase) phaseQ <= phaseQ + 1'b1;
    end
  end

  always_comb begin
    flg.lastBeat = (beatQ == lastIdxQ);
    flg.sendEnd  = (phaseQ == PH_W'(shapeQ.sendCnt - 2'd1));
    flg.restEnd  = (phaseQ == shapeQ.restCnt - 1'b1);
    flg.noRest   = (shapeQ.restCnt == '0);
  end

  assign beatIdx = beatQ;

  // R6: index moves only when a beat is sent or a transfer is loaded
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.advBeat) |=> $stable(beatQ));
  // R3: phase never runs beyond the longest rest group
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ <= PH_W'(MAX_REST));
endmodule

// File: rtl/wb_pacer_ctl.sv
module wb_pacer_ctl
  import wb_pacer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  flags_t  flg,
  output strobe_t stb,
  output logic    dataValid,
  output logic    done
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_REST} state_t;
  state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateD   = ST_SEND;
        end
      end
      ST_SEND: begin
        stb.advBeat = 1'b1;
        if (flg.lastBeat) begin
          stateD = ST_IDLE;
        end else if (flg.sendEnd) begin
          stb.clrPhase = 1'b1;
          stateD = flg.noRest ? ST_SEND : ST_REST;
        end else begin
          stb.incPhase = 1'b1;
        end
      end
      ST_REST: begin
        if (flg.restEnd) begin
          stb.clrPhase = 1'b1;
          stateD = ST_SEND;
        end else begin
          stb.incPhase = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign dataValid = (stateQ == ST_SEND);
  assign done      = dataValid && flg.lastBeat;

  // R2: an accepted start gives a beat in the next cycle
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && start) |=> dataValid);
  // R7: done lasts a single cycle and nothing trails it
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !dataValid));
  // R9: a start during a transfer never reloads the datapath
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != ST_IDLE) |-> !stb.load);
  // R7: done only with a valid beat
  a_r7_done_valid: assert property (@(posedge clk) disable iff (!rstN)
    done |-> dataValid);
endmodule

// File: rtl/wb_pacer.sv
module wb_pacer
  import wb_pacer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CODE_W-1:0] patCode,
  input  logic [SEL_W-1:0]  lineSel,
  output logic              dataValid,
  output logic [IDX_W-1:0]  beatIdx,
  output logic              done
);
  strobe_t stb;
  flags_t  flg;

  wb_pacer_ctl uCtl (
    .clk(clk), .rstN(rstN), .start(start), .flg(flg),
    .stb(stb), .dataValid(dataValid), .done(done)
  );

  wb_pacer_dp uDp (
    .clk(clk), .rstN(rstN), .patCode(patCode), .lineSel(lineSel),
    .stb(stb), .flg(flg), .beatIdx(beatIdx)
  );
endmodule

// File: tb/tb_wb_pacer.sv
module tb_wb_pacer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] patCode = '0;
  logic [1:0] lineSel = '0;
  logic       dataValid, done;
  logic [2:0] beatIdx;
  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wb_pacer dut (.clk(clk), .rstN(rstN), .start(start), .patCode(patCode),
                .lineSel(lineSel), .dataValid(dataValid), .beatIdx(beatIdx),
                .done(done));

  function automatic int sendsOf(input int c);
    int t[16] = '{1,2,2,1,2,2,1,2,1,2,1,2,1,2,1,2};
    return t[c];
  endfunction
  function automatic int restsOf(input int c);
    int t[16] = '{0,1,2,1,3,4,2,5,3,6,4,7,5,8,6,9};
    return t[c];
  endfunction
  function automatic int beatsOf(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
  endfunction
  function automatic int slotOf(input int b, input int s, input int r);
    return (b / s) * (s + r) + (b % s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic runXfer(input int code, input int sel, input bit disturb);
    int s = sendsOf(code);
    int r = restsOf(code);
    int n = beatsOf(sel);
    int last = slotOf(n - 1, s, r);
    @(negedge clk);
    start = 1'b1; patCode = 4'(code); lineSel = 2'(sel);
    for (int cyc = 0; cyc <= last + 3; cyc++) begin
      int expIdx = -1;
      @(negedge clk);
      for (int b = 0; b < n; b++) if (slotOf(b, s, r) == cyc) expIdx = b;
      if (expIdx >= 0) begin
        check(dataValid == 1'b1, "R3/R4 beat slot", int'(dataValid), 1);
        check(int'(beatIdx) == expIdx, "R6 beat index", int'(beatIdx), expIdx);
        check(done == (expIdx == n - 1), "R7 done with last beat", int'(done), int'(expIdx == n - 1));
        if (cyc == 0) check(beatIdx == 3'd0, "R2 first beat", int'(beatIdx), 0);
      end else begin
        check(dataValid == 1'b0, cyc > last ? "R7 no trailing beat" : "R4 rest slot",
              int'(dataValid), 0);
        check(done == 1'b0, "R7 done idle", int'(done), 0);
        if (cyc > last) check(beatIdx == 3'd0, "R6 index back to zero", int'(beatIdx), 0);
      end
      if (disturb && cyc <= last) begin
        start = 1'b1;                 // R9: ignored while busy
        patCode = 4'($urandom_range(15)); // R8: no effect mid-transfer
        lineSel = 2'($urandom_range(3));
      end else begin
        start = 1'b0;
      end
    end
    // R5: count of beats depends on the selector
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    start = 1'b1; patCode = 4'd7;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dataValid == 1'b0 && done == 1'b0 && beatIdx == 3'd0, "R1 reset state",
            int'(dataValid) + int'(done) + int'(beatIdx), 0);
    end
    start = 1'b0;
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(dataValid == 1'b0 && beatIdx == 3'd0, "R1 idle after reset",
            int'(dataValid) + int'(beatIdx), 0);
    end
    runXfer(5, 1, 0);   // R4 send,send,rest x4,send,send
    runXfer(0, 2, 0);   // R10 eight beats without a gap
    runXfer(15, 2, 0);  // longest rest gap
    runXfer(0, 0, 0);   // R5 two beats
    runXfer(3, 3, 0);   // R5 selector 3 means eight beats
    runXfer(9, 2, 1);   // R8 R9 disturbed
    for (int c = 0; c < 16; c++)
      for (int sl = 0; sl < 3; sl++) runXfer(c, sl, 0);   // R3 every code
    for (int k = 0; k < 40; k++)
      runXfer(int'($urandom_range(15)), int'($urandom_range(3)), bit'($urandom_range(1)));
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule